// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Rewind

This block is a FIFO whose write side and read side run on unrelated clocks. Data written on the write clock becomes visible on the read data output without a read request. The oldest unread word sits in an output register, and an output-ready flag says when that word is valid. A read enable consumes the presented word, and the next word falls through behind it.

A rewind input, sampled on the read clock, moves reading back to the first word stored after master reset. Every word written since then is replayed in order, up to the current write position, and no data is thrown away. How the rewind behaves is fixed by a select pin sampled while master reset is low. In the zero-latency mode the first word is already on the output, with output-ready high, right after the read-clock edge that samples the rewind. In the normal mode that edge empties the output register, and the first word falls through on the following edge.

Status flags are computed on each side from that side's own pointer and a Gray-coded copy of the other side's pointer. The read side drives empty and almost-empty. The write side drives full, half-full and almost-full. The storage holds `DEPTH` words and the output register holds one more, so the FIFO takes `DEPTH + 1` words in total.

Top module: `zlrt_fifo`

## Requirements
- R1: While `mrs_n` is low, and after it is released with nothing written, `out_ready` is 0, `empty` is 1, `almost_empty` is 1, and `full`, `half_full` and `almost_full` are 0.
- R2: The first word written appears on `rd_data` with `out_ready` high without any read request. Each read clock edge with `rd_en` and `out_ready` high consumes the presented word, and the words come out in write order. The presented word holds while `rd_en` is low.
- R3: Write level is the number of written words not yet moved into the output register. `full` is 1 when the write level equals `DEPTH`, so the FIFO holds `DEPTH + 1` words in total. A write while `full` is 1 is ignored, and no extra word is ever read out.
- R4: With `rt_mode_sel` low during master reset (zero-latency mode), the read edge that samples `retransmit` high loads the first word written since reset into `rd_data` and sets `out_ready` on that same edge. A simultaneous `rd_en` consumes nothing.
- R5: With `rt_mode_sel` high during master reset (normal mode), the read edge that samples `retransmit` clears `out_ready`. The next read edge presents the first word written since reset, with `out_ready` high.
- R6: After a rewind, reads return every word written since reset, in order starting from the first, up to the write position, and then the FIFO reports empty.
- R7: The read level counts the words in storage not yet fetched plus the word in the output register. `empty` is 1 when the read level is 0. `almost_empty` is 1 when the read level is at most `AE_OFS`.
- R8: `half_full` is 1 when the write level exceeds `DEPTH/2`. `almost_full` is 1 when the write level is at least `DEPTH - AF_OFS`.
- R9: After a rewind, `almost_empty` is recomputed from the rewound read position on the same read edge that samples `retransmit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrs_n | input | 1 | Master reset, active low, synchronous in each clock domain |
| rt_mode_sel | input | 1 | Rewind mode, sampled during reset: 0 selects zero latency, 1 selects normal |
| wr_en | input | 1 | Write enable |
| wr_data | input | DW | Write data |
| full | output | 1 | Write level equals DEPTH |
| half_full | output | 1 | Write level above DEPTH/2 |
| almost_full | output | 1 | Write level at least DEPTH-AF_OFS |
| rd_en | input | 1 | Consume the presented word |
| retransmit | input | 1 | Rewind reading to the first word since reset |
| rd_data | output | DW | Presented word |
| out_ready | output | 1 | `rd_data` holds a valid word |
| empty | output | 1 | Read level is zero |
| almost_empty | output | 1 | Read level at most AE_OFS |

## Verification
The write-side flags change on the write edge that accepts a word, so the bench checks them 1 ns after that edge. A new word reaches `rd_data` only after the write edge, two read-clock synchronizer stages and one fetch edge, so the bench waits twelve read cycles before it checks first-word fall-through. A rewind takes effect on the read edge that samples it: one edge in zero-latency mode, two in normal mode. The bench checks `out_ready`, `rd_data` and `almost_empty` 1 ns after each of those edges. A scoreboard queue, refilled with the full write history on each rewind, checks every consumed word on the read-clock falling edge before the read takes place.

// File: rtl/zlrt_pkg.sv
// Shared types for the rewindable dual-clock FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package zlrt_pkg;

    // Rewind behaviour, latched from the select pin during master reset.
    typedef enum logic {
        RTM_ZERO   = 1'b0,
        RTM_NORMAL = 1'b1
    } rt_mode_e;

endpackage

// File: rtl/zlrt_ptr_sync.sv
// Carries a Gray-coded pointer into another clock domain through two
// flops, then converts it back to binary.
// Assumes: the source register changes by at most one Gray step between
// samples, except around a rewind (see the notes).
module zlrt_ptr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-flop synchronizer, cleared by the local synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the XOR of all higher Gray bits.
    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_out[i] = ^(sync_q >> i);
    end

endmodule

// File: rtl/zlrt_mem.sv
// Dual-port storage: written on the write clock, with two asynchronous
// read ports. One port follows the fetch address, the other is fixed on
// slot 0, the slot that holds the first word after reset.
// Assumes: DEPTH is a power of two. The contents are not reset.
module zlrt_mem #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] head
);

    logic [DW-1:0] mem_q [DEPTH];

    // Store the accepted word.
    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
    assign head  = mem_q[0];

endmodule

// File: rtl/zlrt_wr_ctl.sv
// Write-side control: write pointer in binary and Gray code, storage
// write enable, and the full, half-full and almost-full flags taken from
// the synchronized read pointer.
// Assumes: the read pointer counts the words moved into the output register.
module zlrt_wr_ctl #(
    parameter int DEPTH  = 16,
    parameter int AF_OFS = 2,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic        wclk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [AW:0] rq_bin,
    output logic [AW:0] wptr,
    output logic [AW:0] wgray,
    output logic        mem_we,
    output logic        full,
    output logic        half_full,
    output logic        almost_full
);

    localparam int          PW       = AW + 1;
    localparam logic [AW:0] LIM_FULL = PW'(DEPTH);
    localparam logic [AW:0] LIM_HALF = PW'(DEPTH / 2);
    localparam logic [AW:0] LIM_AF   = PW'(DEPTH - AF_OFS);

    logic [AW:0] wptr_nxt;
    logic [AW:0] wr_level;

    // Fill level seen by the write side, and the flags derived from it.
    always_comb begin
        wr_level    = wptr - rq_bin;
        full        = (wr_level == LIM_FULL);
        half_full   = (wr_level > LIM_HALF);
        almost_full = (wr_level >= LIM_AF);
        mem_we      = wr_en && !full;
        wptr_nxt    = wptr + (mem_we ? PW'(1) : PW'(0));
    end

    // Advance the pointer, and register its Gray form from the next value.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_level <= LIM_FULL); // R3
    AST_FLAG_ORDER: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> (almost_full && half_full)); // R8

endmodule

// File: rtl/zlrt_rd_ctl.sv
// Read-side control: fall-through output register, fetch pointer, rewind
// sequencing in both modes, and the empty and almost-empty flags.
// Assumes: at least two words were written before a rewind is requested,
// and no more than DEPTH-1 words were written before it.
module zlrt_rd_ctl
    import zlrt_pkg::*;
#(
    parameter int DW     = 16,
    parameter int DEPTH  = 16,
    parameter int AE_OFS = 2,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          rd_en,
    input  logic          retx,
    input  logic [AW:0]   wq_bin,
    input  logic [DW-1:0] mem_word,
    input  logic [DW-1:0] mem_head,
    output logic [AW:0]   rptr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          out_ready,
    output logic          empty,
    output logic          almost_empty
);

    localparam int          PW     = AW + 1;
    localparam logic [AW:0] LIM_AE = PW'(AE_OFS);

    rt_mode_e      mode_q;
    logic [AW:0]   rptr_nxt;
    logic          rdy_nxt;
    logic          ld_word;
    logic          ld_head;
    logic          avail;
    logic [AW:0]   rd_level;

    // Latch the rewind mode while master reset is held.
    always_ff @(posedge rclk) begin
        if (!rst_n) mode_q <= rt_mode_e'(mode_sel);
    end

    // Next-state decision: a rewind outranks a fetch, and a fetch outranks a drain.
    always_comb begin
        avail    = (wq_bin != rptr);
        rptr_nxt = rptr;
        rdy_nxt  = out_ready;
        ld_word  = 1'b0;
        ld_head  = 1'b0;
        if (retx) begin
            if (mode_q == RTM_ZERO) begin
                ld_head  = 1'b1;
                rdy_nxt  = 1'b1;
                rptr_nxt = PW'(1);
            end else begin
                rdy_nxt  = 1'b0;
                rptr_nxt = '0;
            end
        end else if ((!out_ready || rd_en) && avail) begin
            ld_word  = 1'b1;
            rdy_nxt  = 1'b1;
            rptr_nxt = rptr + PW'(1);
        end else if (rd_en) begin
            rdy_nxt = 1'b0;
        end
    end

    // Pointer, Gray copy and ready flag.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rptr      <= '0;
            rgray     <= '0;
            out_ready <= 1'b0;
        end else begin
            rptr      <= rptr_nxt;
            rgray     <= rptr_nxt ^ (rptr_nxt >> 1);
            out_ready <= rdy_nxt;
        end
    end

    // Output data register.
    always_ff @(posedge rclk) begin
        if (!rst_n)       rd_data <= '0;
        else if (ld_head) rd_data <= mem_head;
        else if (ld_word) rd_data <= mem_word;
    end

    // Read level includes the word held in the output register.
    always_comb begin
        rd_level     = wq_bin - rptr + {{AW{1'b0}}, out_ready};
        empty        = (rd_level == '0);
        almost_empty = (rd_level <= LIM_AE);
    end

    AST_ZERO_LAT_REWIND: assert property (@(posedge rclk) disable iff (!rst_n)
        (retx && mode_q == RTM_ZERO) |=> (out_ready && rd_data == $past(mem_head))); // R4
    AST_NORMAL_REWIND: assert property (@(posedge rclk) disable iff (!rst_n)
        (retx && mode_q == RTM_NORMAL) |=> !out_ready); // R5
    AST_OUT_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
        (out_ready && !rd_en && !retx) |=> (out_ready && $stable(rd_data))); // R2
    AST_EMPTY_NO_READY: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |-> !out_ready); // R7

endmodule

// File: rtl/zlrt_fifo.sv
// Top level: dual-clock fall-through FIFO with a rewind to the first word
// stored after master reset. Ties together the write control, the
// storage, the read control and the two pointer synchronizers.
// Assumes: mrs_n is held low for several cycles of both clocks, and
// DEPTH is a power of two of at least 4.
module zlrt_fifo #(
    parameter int DW     = 16,
    parameter int DEPTH  = 16,
    parameter int AE_OFS = 2,
    parameter int AF_OFS = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrs_n,
    input  logic          rt_mode_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    output logic          half_full,
    output logic          almost_full,
    input  logic          rd_en,
    input  logic          retransmit,
    output logic [DW-1:0] rd_data,
    output logic          out_ready,
    output logic          empty,
    output logic          almost_empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [AW:0]   wptr, wgray, wq_bin;
    logic [AW:0]   rptr, rgray, rq_bin;
    logic          mem_we;
    logic [DW-1:0] mem_word, mem_head;

    zlrt_wr_ctl #(.DEPTH(DEPTH), .AF_OFS(AF_OFS), .AW(AW)) u_wr (
        .wclk(wclk), .rst_n(mrs_n), .wr_en(wr_en), .rq_bin(rq_bin),
        .wptr(wptr), .wgray(wgray), .mem_we(mem_we), .full(full),
        .half_full(half_full), .almost_full(almost_full)
    );

    zlrt_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wclk), .we(mem_we), .waddr(wptr[AW-1:0]), .wdata(wr_data),
        .raddr(rptr[AW-1:0]), .rdata(mem_word), .head(mem_head)
    );

    zlrt_ptr_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(mrs_n), .gray_in(wgray), .bin_out(wq_bin)
    );

    zlrt_ptr_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(mrs_n), .gray_in(rgray), .bin_out(rq_bin)
    );

    zlrt_rd_ctl #(.DW(DW), .DEPTH(DEPTH), .AE_OFS(AE_OFS), .AW(AW)) u_rd (
        .rclk(rclk), .rst_n(mrs_n), .mode_sel(rt_mode_sel), .rd_en(rd_en),
        .retx(retransmit), .wq_bin(wq_bin), .mem_word(mem_word),
        .mem_head(mem_head), .rptr(rptr), .rgray(rgray), .rd_data(rd_data),
        .out_ready(out_ready), .empty(empty), .almost_empty(almost_empty)
    );

endmodule

// File: tb/zlrt_fifo_tb.sv
// Scoreboard bench: the write task queues expected words, and a monitor
// on the read-clock falling edge pops and compares every consumed word.
module zlrt_fifo_tb;

    localparam int DW    = 16;
    localparam int DEPTH = 16;

    logic wclk = 1'b0, rclk = 1'b0;
    logic mrs_n = 1'b0, rt_mode_sel = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, retransmit = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic full, half_full, almost_full, out_ready, empty, almost_empty;
    logic [DW-1:0] rd_data;

    int checks = 0, errors = 0, pops = 0;
    bit done = 1'b0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] hist[$];

    always #2 wclk = ~wclk;   // 250 MHz write clock
    always #3 rclk = ~rclk;   // slower read clock

    zlrt_fifo #(.DW(DW), .DEPTH(DEPTH), .AE_OFS(2), .AF_OFS(2)) u_dut (
        .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .rt_mode_sel(rt_mode_sel),
        .wr_en(wr_en), .wr_data(wr_data), .full(full), .half_full(half_full),
        .almost_full(almost_full), .rd_en(rd_en), .retransmit(retransmit),
        .rd_data(rd_data), .out_ready(out_ready), .empty(empty),
        .almost_empty(almost_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: a read happens at the next rising edge when these hold.
    always @(negedge rclk) begin
        if (mrs_n && rd_en && out_ready && !retransmit) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 extra word", int'(rd_data), 0);
            end else begin
                chk(rd_data == exp_q[0], "R2/R6 order", int'(rd_data), int'(exp_q[0]));
                void'(exp_q.pop_front());
            end
            pops++;
        end
    end

    task automatic do_reset(input logic mode);
        mrs_n = 1'b0;
        rt_mode_sel = mode;
        exp_q.delete();
        hist.delete();
        repeat (12) @(posedge wclk);
        #1 mrs_n = 1'b1;
        rt_mode_sel = 1'b0;
    endtask

    task automatic wr(input logic [DW-1:0] v, input bit accept);
        @(posedge wclk);
        #1 wr_en = 1'b1;
        wr_data = v;
        @(posedge wclk);
        #1 wr_en = 1'b0;
        if (accept) begin
            exp_q.push_back(v);
            hist.push_back(v);
        end
    endtask

    task automatic rd_n(input int n);
        int target;
        target = pops + n;
        @(posedge rclk);
        #1 rd_en = 1'b1;
        do begin
            @(posedge rclk);
            #1;
        end while (pops < target);
        rd_en = 1'b0;
    endtask

    task automatic rewind(input bit with_rd);
        @(posedge rclk);
        #1 retransmit = 1'b1;
        rd_en = with_rd;
        @(posedge rclk);
        #1 retransmit = 1'b0;
        rd_en = 1'b0;
        exp_q = hist;
    endtask

    initial begin
        // Phase A: zero-latency rewind
        do_reset(1'b0);
        repeat (4) @(posedge rclk);
        #1;
        chk(out_ready == 1'b0, "R1 out_ready", out_ready, 0);
        chk(empty == 1'b1, "R1 empty", empty, 1);
        chk(almost_empty == 1'b1, "R1 almost_empty", almost_empty, 1);
        chk({full, half_full, almost_full} == 3'b000, "R1 write flags",
            {full, half_full, almost_full}, 0);
        for (int i = 0; i < 5; i++) wr(16'hA000 + 16'(i), 1'b1);
        repeat (12) @(posedge rclk);
        #1;
        chk(out_ready == 1'b1, "R2 fall-through ready", out_ready, 1);
        chk(rd_data == hist[0], "R2 fall-through data", rd_data, hist[0]);
        chk(empty == 1'b0 && almost_empty == 1'b0, "R7 level 5 flags",
            {empty, almost_empty}, 0);
        rd_n(3);
        repeat (2) @(posedge rclk);
        #1;
        chk(almost_empty == 1'b1, "R7 level 2 almost_empty", almost_empty, 1);
        rewind(1'b1);
        chk(out_ready == 1'b1, "R4 ready on rewind edge", out_ready, 1);
        chk(rd_data == hist[0], "R4 first word on rewind edge", rd_data, hist[0]);
        chk(almost_empty == 1'b0, "R9 almost_empty after rewind", almost_empty, 0);
        rd_n(5);
        repeat (3) @(posedge rclk);
        #1;
        chk(exp_q.size() == 0, "R6 replay complete", exp_q.size(), 0);
        chk(out_ready == 1'b0 && empty == 1'b1, "R6 empty after replay",
            {out_ready, empty}, 1);

        // Phase B: level flags and full
        do_reset(1'b1);
        wr(16'hB000, 1'b1);
        repeat (12) @(posedge rclk);
        repeat (12) @(posedge wclk);
        for (int k = 2; k <= 17; k++) begin
            wr(16'hB000 + 16'(k), 1'b1);
            if (k == 9)  chk(half_full == 1'b0, "R8 half_full at level 8", half_full, 0);
            if (k == 10) chk(half_full == 1'b1, "R8 half_full at level 9", half_full, 1);
            if (k == 14) chk(almost_full == 1'b0, "R8 almost_full at level 13", almost_full, 0);
            if (k == 15) chk(almost_full == 1'b1, "R8 almost_full at level 14", almost_full, 1);
            if (k == 16) chk(full == 1'b0, "R3 full at level 15", full, 0);
            if (k == 17) chk(full == 1'b1, "R3 full at level 16", full, 1);
        end
        wr(16'hBEEF, 1'b0);
        chk(full == 1'b1, "R3 full holds after ignored write", full, 1);
        rd_n(17);
        repeat (12) @(posedge rclk);
        #1;
        chk(out_ready == 1'b0, "R3 no word after the ignored write", out_ready, 0);
        chk(exp_q.size() == 0, "R3 all words read", exp_q.size(), 0);

        // Phase C: normal-mode rewind
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) wr(16'hC000 + 16'(i), 1'b1);
        repeat (12) @(posedge rclk);
        rd_n(2);
        repeat (2) @(posedge rclk);
        rewind(1'b0);
        chk(out_ready == 1'b0, "R5 ready cleared on rewind edge", out_ready, 0);
        @(posedge rclk);
        #1;
        chk(out_ready == 1'b1, "R5 ready one edge later", out_ready, 1);
        chk(rd_data == hist[0], "R5 first word one edge later", rd_data, hist[0]);
        rd_n(4);
        repeat (3) @(posedge rclk);
        #1;
        chk(exp_q.size() == 0 && empty == 1'b1, "R6 normal-mode replay done",
            exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule